// File: doc/BRIEF.md
# Retrying Single-Beat Bus Master

This block turns requests from a local client into single-beat transfers on a shared, synchronous system bus. A client offers an address, a direction, a transfer size and (for writes) a data word. The block takes the request when idle and then steps through four phases: it asks for the bus, drives one address cycle with the transfer attributes, and holds the data phase until the addressed slave terminates it. Read data and a one-cycle completion pulse go back to the client.

The active-low retry line works in both directions. As an input, a slave can pull it low during the data phase to abort the cycle. The master then drops its bus request for one clock, asks again and replays the identical transfer. After fifteen consecutive retries of one request the block gives up and reports an error instead of looping without limit. As an output, the block pulls the same line low for a single clock when another master occupies the bus while this one is arbitrating, so that the other owner steps aside.

All bus inputs are sampled, and all bus outputs change, on the rising clock edge.

Top module: `bus_retry_master`

## Requirements
- R1: While reset is held and after it, with no request pending, `req_ready` is 1, `bus_req` is 0, `bus_addr_oe`, `bus_dout_oe` and `retry_n_oe` are 0, and `retry_n_out` is 1.
- R2: A request is accepted on an edge where `req_ready` and `req_valid` are both 1. From the next cycle `bus_req` is 1. On the edge where `bus_gnt` is sampled 1, exactly one address cycle follows with `bus_start` 1, carrying the request address and direction. The data phase follows that address cycle.
- R3: The size code `req_size` means 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Code 3 is treated as 4 bytes, so `bus_size` shows 2 for it and the given code otherwise.
- R4: When `bus_ack_n` is sampled 0 in the data phase and `retry_n_in` is 1, `rsp_done` is 1 for exactly the following cycle. For a read, `rsp_rdata` then holds the `bus_din` value sampled on that edge.
- R5: For a write, `bus_dout` equals the request's write data during the data phase. `bus_dout_oe` is 1 only in the data phase, only with the grant held and only for a write.
- R6: `bus_addr_oe` is 1 only in the address cycle and only while `bus_gnt` is 1.
- R7: When `retry_n_in` is sampled 0 in the data phase, `bus_req` is 0 for exactly the following cycle and then returns to 1. The replayed cycle carries the same address, direction, size and write data.
- R8: If `retry_n_in` and `bus_ack_n` are both sampled 0 on the same edge, the retry wins: there is no `rsp_done` in the next cycle and no read data is captured.
- R9: The fifteenth retry of one request ends it with `rsp_done` and `rsp_err` both 1. `rsp_err` stays 1 until the next request is accepted, and a normal completion shows `rsp_err` 0.
- R10: When `bus_ext_busy` is 1 and `bus_gnt` is 0 while the block arbitrates, `retry_n_out` is driven 0 with `retry_n_oe` 1 for exactly one clock, once for each arbitration attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | AW | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code (0:1, 1:2, 2 or 3:4 bytes) |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| rsp_err | output | 1 | Request aborted at retry limit |
| bus_req | output | 1 | Bus request, active high |
| bus_gnt | input | 1 | Bus grant, active high |
| bus_ext_busy | input | 1 | Another master owns the bus |
| bus_start | output | 1 | Address cycle marker |
| bus_addr | output | AW | Address |
| bus_addr_oe | output | 1 | Address/attribute drive enable |
| bus_wr | output | 1 | Direction attribute |
| bus_size | output | 2 | Size attribute |
| bus_dout | output | DW | Write data to bus |
| bus_dout_oe | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low |
| retry_n_in | input | 1 | Retry from slave, active low |
| retry_n_out | output | 1 | Retry value driven to other master |
| retry_n_oe | output | 1 | Retry drive enable |

## Verification
A slave retry and a transfer acknowledge can land on the same sampling edge of the data phase. The bench provokes this by driving both low together in chosen retry rounds, both in directed cases and in random ones. It judges the outcome by requiring the bus request to drop with no completion pulse, and then by checking that the replayed cycle completes with the data of the final acknowledge. The outgoing retry pulse can also coincide with a re-arbitration after a slave retry. The bench counts those pulses against the number of arbitration attempts.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_BACKOFF
  } brm_state_e;

  // size code 3 is folded onto the four-byte code
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // saturating increment used by the retry counter
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/brm_retry_ctr.sv
module brm_retry_ctr
  import brm_pkg::*;
#(
  parameter int unsigned RETRY_MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic limit_hit
);

  localparam int unsigned CW = $clog2(RETRY_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt   = CW'(sat_next(32'(cnt_q), RETRY_MAX));
  assign limit_hit = bump && (32'(cnt_nxt) == RETRY_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/brm_kick.sv
module brm_kick (
  input  logic clk,
  input  logic rst_n,
  input  logic arb,
  input  logic ext_busy,
  input  logic gnt,
  output logic kick
);

  logic kick_q;
  logic fired_q;

  assign kick = kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kick_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      kick_q  <= arb && ext_busy && !gnt && !fired_q && !kick_q;
      fired_q <= arb ? (fired_q || kick_q) : 1'b0;
    end
  end

endmodule

// File: rtl/brm_seq.sv
module brm_seq
  import brm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic          bus_wr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack_n,
  input  logic          retry_n_in,
  input  logic          limit_hit,
  output logic          accept_evt,
  output logic          slave_retry_evt,
  output logic          ack_evt,
  output logic          both_evt,
  output logic          arb_phase
);

  brm_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [1:0]    size_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic          err_q;

  assign req_ready       = (st_q == ST_IDLE);
  assign accept_evt      = req_ready && req_valid;
  assign slave_retry_evt = (st_q == ST_DATA) && !retry_n_in;
  assign ack_evt         = (st_q == ST_DATA) && !bus_ack_n && retry_n_in;
  assign both_evt        = slave_retry_evt && !bus_ack_n;
  assign arb_phase       = (st_q == ST_ARB);

  assign bus_req     = (st_q == ST_ARB) || (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign bus_start   = (st_q == ST_ADDR);
  assign bus_addr_oe = (st_q == ST_ADDR) && bus_gnt;
  assign bus_dout_oe = (st_q == ST_DATA) && bus_gnt && wr_q;
  assign bus_addr    = addr_q;
  assign bus_wr      = wr_q;
  assign bus_size    = size_q;
  assign bus_dout    = wdata_q;

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid) st_d = ST_ARB;
      ST_ARB:     if (bus_gnt) st_d = ST_ADDR;
      ST_ADDR:    st_d = ST_DATA;
      ST_DATA: begin
        if (slave_retry_evt) st_d = limit_hit ? ST_IDLE : ST_BACKOFF;
        else if (ack_evt)    st_d = ST_IDLE;
      end
      ST_BACKOFF: st_d = ST_ARB;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      size_q  <= 2'd0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (slave_retry_evt && limit_hit) || ack_evt;
      if (accept_evt) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        size_q  <= norm_size(req_size);
        wdata_q <= req_wdata;
        err_q   <= 1'b0;
      end
      if (slave_retry_evt && limit_hit) err_q <= 1'b1;
      if (ack_evt && !wr_q) rdata_q <= bus_din;
    end
  end

endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master #(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned RETRY_MAX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          bus_ext_busy,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic          bus_wr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack_n,
  input  logic          retry_n_in,
  output logic          retry_n_out,
  output logic          retry_n_oe
);

  logic accept_evt;
  logic slave_retry_evt;
  logic ack_evt;
  logic both_evt;
  logic arb_phase;
  logic limit_hit;
  logic kick;

  brm_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_addr        (req_addr),
    .req_write       (req_write),
    .req_size        (req_size),
    .req_wdata       (req_wdata),
    .rsp_done        (rsp_done),
    .rsp_rdata       (rsp_rdata),
    .rsp_err         (rsp_err),
    .bus_req         (bus_req),
    .bus_gnt         (bus_gnt),
    .bus_start       (bus_start),
    .bus_addr        (bus_addr),
    .bus_addr_oe     (bus_addr_oe),
    .bus_wr          (bus_wr),
    .bus_size        (bus_size),
    .bus_dout        (bus_dout),
    .bus_dout_oe     (bus_dout_oe),
    .bus_din         (bus_din),
    .bus_ack_n       (bus_ack_n),
    .retry_n_in      (retry_n_in),
    .limit_hit       (limit_hit),
    .accept_evt      (accept_evt),
    .slave_retry_evt (slave_retry_evt),
    .ack_evt         (ack_evt),
    .both_evt        (both_evt),
    .arb_phase       (arb_phase)
  );

  brm_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept_evt),
    .bump      (slave_retry_evt),
    .limit_hit (limit_hit)
  );

  brm_kick u_kick (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb      (arb_phase),
    .ext_busy (bus_ext_busy),
    .gnt      (bus_gnt),
    .kick     (kick)
  );

  assign retry_n_out = !kick;
  assign retry_n_oe  = kick;

endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_start,
  input logic          bus_addr_oe,
  input logic          bus_wr,
  input logic          bus_dout_oe,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          retry_n_out,
  input logic          slave_retry_evt,
  input logic          both_evt,
  input logic          limit_hit
);

  // R6
  addr_oe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_oe |-> (bus_gnt && bus_start));

  // R5
  dout_oe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_oe |-> (bus_gnt && bus_wr));

  // R7
  backoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_retry_evt && !limit_hit) |=> !bus_req ##1 bus_req);

  // R7
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(bus_addr) && $stable(bus_dout) && $stable(bus_wr)));

  // R8
  retry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_evt && !limit_hit |=> !rsp_done);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  kick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_n_out |=> retry_n_out);

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err) |-> rsp_done);

  // R9
  limit_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> (rsp_done && rsp_err && req_ready));

endmodule

bind bus_retry_master brm_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .rsp_done        (rsp_done),
  .rsp_err         (rsp_err),
  .bus_req         (bus_req),
  .bus_gnt         (bus_gnt),
  .bus_start       (bus_start),
  .bus_addr_oe     (bus_addr_oe),
  .bus_wr          (bus_wr),
  .bus_dout_oe     (bus_dout_oe),
  .bus_addr        (bus_addr),
  .bus_dout        (bus_dout),
  .retry_n_out     (retry_n_out),
  .slave_retry_evt (slave_retry_evt),
  .both_evt        (both_evt),
  .limit_hit       (limit_hit)
);

// File: tb/sim_bus_retry_master.sv
module sim_bus_retry_master;

  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          bus_ext_busy = 1'b0;
  logic          bus_start;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_oe;
  logic          bus_wr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_dout;
  logic          bus_dout_oe;
  logic [DW-1:0] bus_din = '0;
  logic          bus_ack_n = 1'b1;
  logic          retry_n_in = 1'b1;
  logic          retry_n_out;
  logic          retry_n_oe;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_retry_master u0 (.*);

  function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [1:0] want_size(input logic [1:0] code);
    return (code > 2'd2) ? 2'd2 : code;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input bit w, input logic [1:0] sz,
                         input logic [DW-1:0] wd, input int nret, input int gdel,
                         input int adel, input bit both, input bit ext);
    int rleft;
    int wc;
    int ac;
    int nr;
    int kicks;
    int arbs;
    int guard;
    bit prev_start;
    bit in_data;
    bit first_data;
    bit pending;
    bit was_retry;
    bit fin;
    logic [DW-1:0] old_rdata;
    rleft = nret; wc = 0; ac = 0; nr = 0; kicks = 0; arbs = 1; guard = 0;
    prev_start = 0; in_data = 0; first_data = 0; pending = 0; was_retry = 0; fin = 0;
    old_rdata = rsp_rdata;
    @(negedge clk);
    req_addr = a; req_write = w; req_size = sz; req_wdata = wd; req_valid = 1'b1;
    bus_ext_busy = ext;
    @(negedge clk);
    req_valid = 1'b0;
    // R2: request taken, bus request raised
    chk(!req_ready && bus_req, "R2 accept", {62'd0, req_ready, bus_req}, 64'd1);
    while (!fin && guard < 2000) begin
      if (!retry_n_out) kicks++;
      if (prev_start) begin
        in_data = 1; first_data = 1; prev_start = 0;
      end
      if (pending) begin
        pending = 0; bus_ack_n = 1'b1; retry_n_in = 1'b1;
        if (was_retry) begin
          nr++;
          if (nr >= 15) begin
            // R9: limit reached
            chk(rsp_done && rsp_err, "R9 abort", {62'd0, rsp_done, rsp_err}, 64'd3);
            fin = 1;
          end else begin
            // R7 backoff, R8 retry beats ack
            chk(!bus_req, "R7 backoff", {63'd0, bus_req}, 64'd0);
            chk(!rsp_done, "R8 no done on retry", {63'd0, rsp_done}, 64'd0);
            if (!w) chk(rsp_rdata == old_rdata, "R8 no capture", rsp_rdata, old_rdata);
            arbs++;
          end
        end else begin
          chk(rsp_done && !rsp_err, "R4 done", {62'd0, rsp_done, rsp_err}, 64'd2);
          if (!w) chk(rsp_rdata == slave_word(a), "R4 rdata", rsp_rdata, slave_word(a));
          fin = 1;
        end
      end else if (in_data) begin
        if (first_data) begin
          first_data = 0;
          if (w) chk(bus_dout_oe && bus_dout == wd, "R5 wdata", bus_dout, wd);
          else   chk(!bus_dout_oe, "R5 read oe", {63'd0, bus_dout_oe}, 64'd0);
        end
        if (ac < adel) begin
          ac++;
        end else begin
          if (rleft > 0) begin
            retry_n_in = 1'b0;
            if (both) begin bus_ack_n = 1'b0; bus_din = ~slave_word(a); end
            rleft--; was_retry = 1;
          end else begin
            bus_ack_n = 1'b0; bus_din = slave_word(a); was_retry = 0;
          end
          pending = 1; in_data = 0; ac = 0;
        end
      end
      if (bus_start) begin
        chk(bus_addr == a && bus_wr == w, "R2/R7 addr attr", bus_addr, a);
        chk(bus_size == want_size(sz), "R3 size", {62'd0, bus_size}, {62'd0, want_size(sz)});
        chk(bus_addr_oe, "R6 addr oe", {63'd0, bus_addr_oe}, 64'd1);
        prev_start = 1;
      end else if (!fin) begin
        chk(!bus_addr_oe, "R6 addr oe off", {63'd0, bus_addr_oe}, 64'd0);
      end
      if (!bus_req || fin) begin
        bus_gnt = 1'b0; wc = 0;
      end else if (!bus_gnt) begin
        wc++;
        if (wc > gdel) bus_gnt = 1'b1;
      end
      bus_ext_busy = ext && !bus_gnt && !fin;
      if (!fin) begin
        @(negedge clk);
        guard++;
      end
    end
    if (!fin) chk(0, "R2 hang", guard, 0);
    bus_ext_busy = 1'b0; bus_gnt = 1'b0;
    // R10: one kick per arbitration attempt when contended
    chk(kicks == (ext ? arbs : 0), "R10 kicks", kicks, ext ? arbs : 0);
    @(negedge clk);
    chk(!rsp_done && req_ready, "R4 pulse width", {62'd0, rsp_done, req_ready}, 64'd1);
    chk(rsp_err == (nret >= 15), "R9 err level", {63'd0, rsp_err}, {63'd0, nret >= 15});
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    // R1: state while reset held
    chk(req_ready && !bus_req && !bus_addr_oe && !bus_dout_oe && !retry_n_oe && retry_n_out,
        "R1 reset", {58'd0, req_ready, bus_req, bus_addr_oe, bus_dout_oe, retry_n_oe, retry_n_out},
        64'h21);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_req && retry_n_out, "R1 idle", {61'd0, req_ready, bus_req, retry_n_out},
        64'h5);
    // directed corners
    run_txn(32'h0000_1000, 1'b0, 2'd3, '0, 0, 0, 0, 1'b0, 1'b0);          // R3 code 3
    run_txn(32'h0000_2004, 1'b1, 2'd1, 32'hCAFE_0001, 0, 2, 1, 1'b0, 1'b0); // R5
    run_txn(32'h0000_3008, 1'b0, 2'd2, '0, 2, 1, 0, 1'b1, 1'b0);          // R8 both
    run_txn(32'h0000_400C, 1'b1, 2'd0, 32'h1234_5678, 1, 2, 0, 1'b0, 1'b1); // R10
    run_txn(32'h0000_5010, 1'b0, 2'd2, '0, 15, 1, 0, 1'b1, 1'b0);         // R9 abort
    run_txn(32'h0000_6014, 1'b0, 2'd2, '0, 14, 1, 0, 1'b0, 1'b1);         // R9 last good
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] ra;
      int nr;
      ra = $urandom();
      nr = ($urandom_range(0, 9) == 0) ? 15 : $urandom_range(0, 3);
      run_txn(ra, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom(), nr,
              $urandom_range(1, 3), $urandom_range(0, 2), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule